// File: doc/BRIEF.md
# I2C Slave with Dual Address Match

This block is a single-channel I2C slave. It compares every address byte that follows a start condition against two programmable 7-bit slave addresses and against the general call address. When either case matches, it acknowledges and then acts as a receiver or a transmitter, depending on the direction bit of the address byte. The SCL and SDA pins are open drain. Each pin is modelled as an input plus a drive-low enable. Both pins are sampled on the system clock through a short synchronizer. Start and stop are recognised as an SDA edge while SCL is high.

Software reaches the block through a small register port with four byte registers: two address slots, a data register and a control/status register. During reception, the level driven in the acknowledge slot of each data byte comes from a control bit. After each data byte the slave can hold SCL low until software services the data register. In receive mode this means software has read the byte. In transmit mode it means software has written the next byte. The slave flags an address match, a general call and a stop that ends a transfer in which it was addressed.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, the control/status register (offset 3) reads 0x00, and neither SCL nor SDA is driven low.
- R2: An address byte whose upper seven bits equal the address of an enabled slot is acknowledged (SDA low in the ninth clock). Slot registers are at offset 0 and offset 1, with bit 7 as the enable and bits 6:0 as the address. The match flag (status bit 1) is set, and status bit 7 gives the matching slot, with the lower slot taking priority.
- R3: An address byte that matches no enabled slot and is not a general call is not acknowledged and sets no flag. The slave then ignores all bytes up to the next start: it gives no acknowledge and stores no data.
- R4: The byte 0x00 is acknowledged as a general call and sets both the match flag and the general call flag (status bit 3). The byte 0x01 is not a general call.
- R5: In receive mode, the slave drives the acknowledge slot of each data byte to the level of control bit 0 (written at offset 3). A 0 pulls SDA low and a 1 leaves it released.
- R6: After the ninth clock of a received data byte, SCL is held low while that byte is unread. Status bit 5 shows unread data and status bit 6 shows the hold. Reading the data register (offset 2) returns the byte and releases SCL.
- R7: An address byte with bit 0 set selects transmit mode (status bit 4), and bytes are then sent MSB first. When a byte has to start and no data has been written, SCL is held low until the data register is written. Data written in advance is sent without a hold.
- R8: If the master does not acknowledge a transmitted byte, the slave releases SDA and drives nothing more until the next start.
- R9: A stop condition that ends a transfer in which the slave was addressed sets the stop flag (status bit 2). A stop after an unmatched address does not set it.
- R10: Writing a 1 to status bit 1, 2 or 3 at offset 3 clears that flag. Writing a 0 to the bit leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_drive_o | output | 1 | Pull SCL low (wait request) |
| sda_drive_o | output | 1 | Pull SDA low |
| reg_addr_i | input | 2 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; a data register read releases a receive hold |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the offset presented |

## Verification
The hardest states to reach from the ports are the SCL holds. A hold exists only at the precise low phase after a ninth clock, and it clears only on a register access. The bench master therefore checks the drive-low enable during that low phase, before it tries to raise SCL, then performs the data register access and checks that the pin is released.

The transmit path also covers a transfer ended by a not-acknowledge. After that, further clocks must read back all ones, while a byte already written waits unsent in the data register. Random trials program both slots with random addresses and enables and send addresses drawn from the slots, at random, or as the general call. Each outcome is compared against a reference match function.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned ADDR_W = 7;

  localparam logic [1:0] REG_SLOT0 = 2'd0;
  localparam logic [1:0] REG_SLOT1 = 2'd1;
  localparam logic [1:0] REG_DATA  = 2'd2;
  localparam logic [1:0] REG_CTRL  = 2'd3;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK0, ST_AACK1,
    ST_RX, ST_RACK0, ST_RACK1,
    ST_TX, ST_TACK, ST_DONE
  } state_e;
endpackage

// File: rtl/i2cs_bus_sync.sv
module i2cs_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;
  logic scl_c, scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_c = scl_sh[DEPTH-2];
  assign scl_p = scl_sh[DEPTH-1];
  assign sda_o = sda_sh[DEPTH-2];
  assign sda_p = sda_sh[DEPTH-1];

  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  // SDA edges only count while SCL stays high across both samples
  assign start_o    = scl_c & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  slot_t [NUM_SLOTS-1:0] slots_i,
  input  logic  [ADDR_W:0]      byte_i,
  output logic                  hit_o,
  output logic                  gcall_o,
  output logic  [IDX_W-1:0]     idx_o
);
  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_hit[g] = slots_i[g].en && (slots_i[g].addr == byte_i[ADDR_W:1]);
  end

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_hit[i]) idx_o = IDX_W'(i);
    end
  end

  assign gcall_o = (byte_i == '0);
  assign hit_o   = (|slot_hit) | gcall_o;
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_o,
  output logic       sda_drive_o,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned BYTE_W    = ADDR_W + 1;
  localparam int unsigned CNT_W     = $clog2(BYTE_W);
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit, gcall;
  logic [IDX_W-1:0] hit_idx;

  slot_t [NUM_SLOTS-1:0] slot_q;
  state_e                state_q;
  logic [CNT_W-1:0]      bit_q;
  logic [ADDR_W-1:0]     rx_sh_q;
  logic [BYTE_W-1:0]     rx_q, tx_q, tx_sh_q, in_byte;
  logic tx_valid_q, rx_full_q, pend_q, sda_drv_q, tx_on_q, tx_mode_q;
  logic addressed_q, ack_lvl_q, match_q, stop_q, gcall_q, mack_q;
  logic [IDX_W-1:0] slot_idx_q;
  logic wr_ctrl, wr_data, rd_data;

  i2cs_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign in_byte = {rx_sh_q, sda_s};

  i2cs_addr_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .slots_i(slot_q), .byte_i(in_byte),
    .hit_o(hit), .gcall_o(gcall), .idx_o(hit_idx)
  );

  assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign wr_data = reg_wr_i && (reg_addr_i == REG_DATA);
  assign rd_data = reg_rd_i && (reg_addr_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0; state_q <= ST_IDLE; bit_q <= '0;
      rx_sh_q <= '0; rx_q <= '0; tx_q <= '0; tx_sh_q <= '0;
      tx_valid_q <= 1'b0; rx_full_q <= 1'b0; pend_q <= 1'b0;
      sda_drv_q <= 1'b0; tx_on_q <= 1'b0; tx_mode_q <= 1'b0;
      addressed_q <= 1'b0; ack_lvl_q <= 1'b0; match_q <= 1'b0;
      stop_q <= 1'b0; gcall_q <= 1'b0; mack_q <= 1'b0; slot_idx_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (reg_wr_i && reg_addr_i == 2'(i)) slot_q[i] <= reg_wdata_i;
      end
      if (wr_ctrl) begin
        ack_lvl_q <= reg_wdata_i[0];
        if (reg_wdata_i[1]) match_q <= 1'b0;
        if (reg_wdata_i[2]) stop_q  <= 1'b0;
        if (reg_wdata_i[3]) gcall_q <= 1'b0;
      end
      if (rd_data) rx_full_q <= 1'b0;

      if (start_det) begin
        state_q <= ST_ADDR; bit_q <= '0; sda_drv_q <= 1'b0; tx_on_q <= 1'b0;
        pend_q <= 1'b0; tx_mode_q <= 1'b0; addressed_q <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE; sda_drv_q <= 1'b0; tx_on_q <= 1'b0;
        pend_q <= 1'b0; tx_mode_q <= 1'b0; addressed_q <= 1'b0;
        if (addressed_q) stop_q <= 1'b1;
      end else if (pend_q) begin
        // wait request: release once the data register is serviced
        if (tx_mode_q) begin
          if (tx_valid_q) begin
            tx_sh_q <= tx_q; tx_on_q <= 1'b1; tx_valid_q <= 1'b0; pend_q <= 1'b0;
          end
        end else if (!rx_full_q) begin
          pend_q <= 1'b0;
        end
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            rx_sh_q <= in_byte[ADDR_W-1:0];
            bit_q   <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) begin
              if (hit) begin
                state_q <= ST_AACK0; match_q <= 1'b1; addressed_q <= 1'b1;
                gcall_q <= gcall; tx_mode_q <= sda_s;
                if (!gcall) slot_idx_q <= hit_idx;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK0: if (scl_fall) begin sda_drv_q <= 1'b1; state_q <= ST_AACK1; end
          ST_AACK1: if (scl_fall) begin
            sda_drv_q <= 1'b0; bit_q <= '0; pend_q <= tx_mode_q;
            state_q <= tx_mode_q ? ST_TX : ST_RX;
          end
          ST_RX: if (scl_rise) begin
            rx_sh_q <= in_byte[ADDR_W-1:0];
            bit_q   <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) begin
              rx_q <= in_byte; rx_full_q <= 1'b1; state_q <= ST_RACK0;
            end
          end
          ST_RACK0: if (scl_fall) begin sda_drv_q <= ~ack_lvl_q; state_q <= ST_RACK1; end
          ST_RACK1: if (scl_fall) begin
            sda_drv_q <= 1'b0; bit_q <= '0; pend_q <= 1'b1; state_q <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              tx_on_q <= 1'b0; state_q <= ST_TACK;
            end else begin
              tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
            end
          end
          ST_TACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                pend_q <= 1'b1; bit_q <= '0; state_q <= ST_TX;
              end else begin
                state_q <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end

      if (wr_data) begin
        tx_q <= reg_wdata_i; tx_valid_q <= 1'b1;
      end
    end
  end

  assign scl_drive_o = pend_q;
  assign sda_drive_o = sda_drv_q | (tx_on_q & ~tx_sh_q[BYTE_W-1]);

  always_comb begin
    unique case (reg_addr_i)
      REG_SLOT0: reg_rdata_o = slot_q[0];
      REG_SLOT1: reg_rdata_o = slot_q[1];
      REG_DATA:  reg_rdata_o = rx_q;
      default:   reg_rdata_o = {slot_idx_q[0], pend_q, rx_full_q, tx_mode_q,
                                gcall_q, stop_q, match_q, ack_lvl_q};
    endcase
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input state_e state_i,
  input logic   scl_drive_i,
  input logic   sda_drive_i,
  input logic   tx_mode_i,
  input logic   rx_full_i,
  input logic   gcall_i,
  input logic   match_i,
  input logic   stop_i,
  input logic   stop_det_i,
  input logic   addressed_i
);
  assert_sda_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE || state_i == ST_DONE) |-> !sda_drive_i);

  assert_hold_after_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drive_i |-> (state_i == ST_RX || state_i == ST_TX));

  assert_rx_hold_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_drive_i && !tx_mode_i && !rx_full_i) |=> !scl_drive_i);

  assert_gcall_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gcall_i) |-> match_i);

  assert_addr_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addressed_i) |-> match_i);

  assert_stop_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && addressed_i) |=> stop_i);
endmodule

bind i2c_dual_slave i2cs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q),
  .scl_drive_i(scl_drive_o), .sda_drive_i(sda_drive_o),
  .tx_mode_i(tx_mode_q), .rx_full_i(rx_full_q), .gcall_i(gcall_q),
  .match_i(match_q), .stop_i(stop_q), .stop_det_i(stop_det),
  .addressed_i(addressed_q)
);

// File: tb/tb_i2c_dual_slave.sv
module tb_i2c_dual_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_bus, sda_bus, scl_drv, sda_drv;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = m_scl & ~scl_drv;
  assign sda_bus = m_sda & ~sda_drv;

  i2c_dual_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_o(scl_drv), .sda_drive_o(sda_drv),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  function automatic bit ref_hit(input logic [7:0] ab, input logic [7:0] s0, input logic [7:0] s1);
    return (ab == 8'h00) || (s0[7] && s0[6:0] == ab[7:1]) || (s1[7] && s1[6:0] == ab[7:1]);
  endfunction

  function automatic bit ref_slot(input logic [7:0] ab, input logic [7:0] s0);
    return !(s0[7] && s0[6:0] == ab[7:1]);
  endfunction

  task automatic hwait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; hwait();
    m_sda = 1'b0; hwait();
    m_scl = 1'b0; hwait();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hwait();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_bus);
    hwait(); m_sda = 1'b1; hwait();
  endtask

  task automatic m_bit(input bit b, output bit r);
    m_sda = b; hwait();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_bus);
    hwait(); r = sda_bus;
    m_scl = 1'b0; hwait();
  endtask

  task automatic m_write(input logic [7:0] b, output bit nack);
    bit r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, nack);
  endtask

  task automatic m_read(output logic [7:0] d, input bit give_ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(!give_ack, r);
  endtask

  initial begin
    logic [7:0] st, s0, s1, ab, d, got;
    bit nack, exp_hit;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cpu_rd(2'd3, st);
    chk(st == 8'h00, "R1 status", st, 0);
    chk(!scl_drv && !sda_drv, "R1 pins", {scl_drv, sda_drv}, 0);

    // R2 R3 R4 R9 R10 random address trials
    for (int t = 0; t < 16; t++) begin
      s0 = 8'($urandom); s1 = 8'($urandom);
      case ($urandom % 4)
        0: ab = {s0[6:0], 1'b0};
        1: ab = {s1[6:0], 1'b0};
        2: ab = 8'($urandom) & 8'hFE;
        default: ab = 8'h00;
      endcase
      exp_hit = ref_hit(ab, s0, s1);
      cpu_wr(2'd0, s0); cpu_wr(2'd1, s1); cpu_wr(2'd3, 8'h0E);
      m_start(); m_write(ab, nack);
      chk(nack == !exp_hit, "R2/R3 address ack", nack, !exp_hit);
      cpu_rd(2'd3, st);
      chk(st[1] == exp_hit, "R2 match flag", st[1], exp_hit);
      chk(st[3] == (ab == 8'h00), "R4 general call flag", st[3], ab == 8'h00);
      if (exp_hit && ab != 8'h00)
        chk(st[7] == ref_slot(ab, s0), "R2 slot index", st[7], ref_slot(ab, s0));
      m_stop();
      cpu_rd(2'd3, st);
      chk(st[2] == exp_hit, "R9 stop flag", st[2], exp_hit);
      cpu_wr(2'd3, 8'h0E); cpu_rd(2'd3, st);
      chk(st[3:1] == 3'b000, "R10 w1c clear", st[3:1], 0);
    end

    // R4 0x01 is no general call; R3 bytes after a miss are ignored
    cpu_wr(2'd0, 8'h00); cpu_wr(2'd1, 8'h00); cpu_wr(2'd3, 8'h0E);
    m_start(); m_write(8'h01, nack);
    chk(nack == 1'b1, "R4 0x01 not acked", nack, 1);
    m_write(8'h5A, nack);
    chk(nack == 1'b1, "R3 data after miss", nack, 1);
    cpu_rd(2'd3, st);
    chk(st[5] == 1'b0 && st[3:1] == 3'b000, "R3 nothing stored", st, 0);
    m_stop();
    cpu_rd(2'd3, st);
    chk(st[2] == 1'b0, "R9 no stop flag unaddressed", st[2], 0);

    // R5 R6 receive with both ack levels and SCL hold
    cpu_wr(2'd0, 8'hAA);
    m_start(); m_write(8'h54, nack);
    chk(nack == 1'b0, "R2 slot0 ack", nack, 0);
    cpu_wr(2'd3, 8'h00); cpu_rd(2'd3, st);
    chk(st[1] == 1'b1, "R10 write 0 keeps flag", st[1], 1);
    for (int k = 0; k < 4; k++) begin
      bit lvl;
      lvl = k[0];
      d = 8'($urandom);
      cpu_wr(2'd3, {7'd0, lvl});
      m_write(d, nack);
      chk(nack == lvl, "R5 ack level", nack, lvl);
      chk(scl_drv == 1'b1, "R6 hold while unread", scl_drv, 1);
      cpu_rd(2'd3, st);
      chk(st[6:5] == 2'b11, "R6 status hold and full", st[6:5], 3);
      cpu_rd(2'd2, got);
      chk(got == d, "R6 received byte", got, d);
      repeat (3) @(negedge clk);
      chk(scl_drv == 1'b0, "R6 hold released", scl_drv, 1'b0);
    end
    m_stop();
    cpu_wr(2'd3, 8'h0E);

    // R7 R8 transmit with data written in advance
    cpu_wr(2'd1, 8'h91);
    d = 8'($urandom);
    cpu_wr(2'd2, d);
    m_start(); m_write(8'h23, nack);
    chk(nack == 1'b0, "R7 read address ack", nack, 0);
    m_read(got, 1'b0);
    chk(got == d, "R7 prewritten byte", got, d);
    m_stop();

    // R7 hold until written, then NACK end R8
    m_start(); m_write(8'h23, nack);
    cpu_rd(2'd3, st);
    chk(st[4] == 1'b1, "R7 transmit mode", st[4], 1);
    chk(scl_drv == 1'b1, "R7 hold without data", scl_drv, 1);
    d = 8'($urandom);
    cpu_wr(2'd2, d);
    m_read(got, 1'b1);
    chk(got == d, "R7 byte after hold", got, d);
    chk(scl_drv == 1'b1, "R7 hold for next byte", scl_drv, 1);
    d = 8'($urandom);
    cpu_wr(2'd2, d);
    m_read(got, 1'b0);
    chk(got == d, "R7 second byte", got, d);
    cpu_wr(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    chk(!sda_drv && !scl_drv, "R8 released after NACK", {scl_drv, sda_drv}, 0);
    m_read(got, 1'b0);
    chk(got == 8'hFF, "R8 nothing driven", got, 8'hFF);
    m_stop();
    cpu_rd(2'd3, st);
    chk(st[2] == 1'b1, "R9 stop after transmit", st[2], 1);

    summary();
  end
endmodule